// File: doc/BRIEF.md
# Periodic Tick Interrupt Timer

This block produces a periodic interrupt from the free-running oscillator clock. Software sets the period through one 7-bit control register. That register holds two cascaded selections. The first is a binary prescale exponent, which picks a power-of-two division. The second is a modulus select, which multiplies that division by a value from 1 to 16. Each time the selected period runs out, the block sets a sticky event flag. Software clears the flag by writing a one to it. The interrupt line is the flag gated by an enable bit.

A second register holds the interrupt enable, the flag and a run-in-pseudo-stop bit. The pseudo-stop bit decides what happens while the `pstop` input is high. With the bit set, the divider chain keeps counting. With the bit clear, the chain freezes and keeps its count, then resumes from that point once `pstop` falls.

Any write to the control register restarts the whole chain. A prescale select of zero turns the timer off and holds its counters cleared. Both registers can be read and written at any time. A read returns its data one clock after the read strobe.

Top module: `rti_timer`

## Requirements
- R1: Control register (address 0) layout. The modulus select M sits in bits 3:0 and the prescale select P in bits 6:4. Bit 7 is always read as 0, whatever value was written. The register can be written and read at any time, and a read returns its data on `bus_rdata` one clock after `bus_rd`.
- R2: After reset, both registers read as 0x00 and `irq` is low.
- R3: Period. P is nonzero here. The flag becomes set on the clock edge that lies (M+1)·2^(P+BASE_EXP) edges after the edge that captured the control write. It then sets again every period after that. BASE_EXP defaults to 9.
- R4: Any write to the control register restarts both counters, even when the written value is unchanged.
- R5: With P = 0 the timer is off and the flag never sets.
- R6: Freeze. While `pstop` is high and the run-in-pseudo-stop bit (bit 1 of address 1) is 0, the counters hold their value. When `pstop` falls, counting resumes from the held count without any reset.
- R7: While `pstop` is high and the run-in-pseudo-stop bit is 1, the timer keeps counting normally.
- R8: The flag (bit 7 of address 1) stays set until software writes 1 to that bit. Writing 0 to the bit leaves the flag unchanged. When an expiry and a clearing write land on the same edge, the expiry wins and the flag stays set.
- R9: `irq` equals the flag ANDed with the interrupt enable, which is bit 0 of address 1.
- R10: Address 1 reads back the flag in bit 7, the run-in-pseudo-stop bit in bit 1 and the enable in bit 0. Bits 6:2 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all counting runs on it |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register select: 0 control, 1 config/flag |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pstop | input | 1 | Pseudo-stop mode active |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
Some properties are checked by assertions on every cycle. A control write clears the prescale counter. A frozen prescale counter holds still. The modulus count never goes past the selected modulus. An expiry always leaves the flag set on the next cycle, and the flag never drops without a clearing write. A disabled timer never expires. Other behaviour only the bench scenarios can show. These are the exact period for every P and M pair, the cycle at which a frozen count finishes after pseudo-stop ends, and the restart that a same-value rewrite causes. They also include the expiry winning over a clear on the same edge, and the readback of each register's unused bits.

// File: rtl/rti_pkg.sv
package rti_pkg;
  // register addresses
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_CFG  = 1;
  // bit positions inside the config/flag register
  localparam int unsigned CFG_IE_BIT   = 0;
  localparam int unsigned CFG_KEEP_BIT = 1;
endpackage

// File: rtl/rti_prescaler.sv
module rti_prescaler #(
  parameter int unsigned PRE_W    = 3,
  parameter int unsigned BASE_EXP = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_sel,
  output logic             tick
);
  localparam int unsigned SHIFT_MAX = (1 << PRE_W) - 1;
  localparam int unsigned CNT_W     = BASE_EXP + SHIFT_MAX;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [PRE_W-1:0] shamt;

  // terminal count is 2^(pre_sel+BASE_EXP)-1
  always_comb begin
    shamt = PRE_W'(SHIFT_MAX) - pre_sel;
    limit = {CNT_W{1'b1}} >> shamt;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == limit) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && !clr && (cnt == limit);

  p_clear_restarts_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  p_freeze_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(cnt));
endmodule

// File: rtl/rti_modulus.sv
module rti_modulus #(
  parameter int unsigned MOD_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [MOD_W-1:0] mod_sel,
  output logic             expire
);
  logic [MOD_W-1:0] mcnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mcnt <= '0;
    end else if (tick) begin
      if (mcnt == mod_sel) mcnt <= '0;
      else                 mcnt <= mcnt + 1'b1;
    end
  end

  assign expire = tick && (mcnt == mod_sel);

  p_mod_bound_r3: assert property (@(posedge clk) disable iff (rst)
    mcnt <= mod_sel);
endmodule

// File: rtl/rti_regs.sv
module rti_regs
  import rti_pkg::*;
#(
  parameter int unsigned ADDR_W = 1,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PRE_W  = 3,
  parameter int unsigned MOD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              expire,
  output logic              ctrl_wr,
  output logic [PRE_W-1:0]  pre_sel,
  output logic [MOD_W-1:0]  mod_sel,
  output logic              irq_en,
  output logic              keep_run,
  output logic              flag
);
  localparam int unsigned CTRL_W = PRE_W + MOD_W;

  logic hit_ctrl, hit_cfg, flag_clr;
  logic [DATA_W-1:0] rd_mux;

  assign hit_ctrl = (bus_addr == ADDR_W'(ADDR_CTRL));
  assign hit_cfg  = (bus_addr == ADDR_W'(ADDR_CFG));
  assign ctrl_wr  = bus_wr && hit_ctrl;
  assign flag_clr = bus_wr && hit_cfg && bus_wdata[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_sel  <= '0;
      mod_sel  <= '0;
      irq_en   <= 1'b0;
      keep_run <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mod_sel <= bus_wdata[MOD_W-1:0];
        pre_sel <= bus_wdata[CTRL_W-1:MOD_W];
      end
      if (bus_wr && hit_cfg) begin
        irq_en   <= bus_wdata[CFG_IE_BIT];
        keep_run <= bus_wdata[CFG_KEEP_BIT];
      end
    end
  end

  // an expiry on the same edge as a clear keeps the flag set
  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (expire)   flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[CTRL_W-1:0] = {pre_sel, mod_sel};
    end else if (hit_cfg) begin
      rd_mux[DATA_W-1]     = flag;
      rd_mux[CFG_KEEP_BIT] = keep_run;
      rd_mux[CFG_IE_BIT]   = irq_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  p_ctrl_msb_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit_ctrl) |=> !bus_rdata[DATA_W-1]);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag);
endmodule

// File: rtl/rti_timer.sv
module rti_timer #(
  parameter int unsigned ADDR_W   = 1,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PRE_W    = 3,
  parameter int unsigned MOD_W    = 4,
  parameter int unsigned BASE_EXP = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pstop,
  output logic              irq
);
  logic             ctrl_wr, irq_en, keep_run, flag;
  logic [PRE_W-1:0] pre_sel;
  logic [MOD_W-1:0] mod_sel;
  logic             enabled, run, chain_clr, tick, expire;

  assign enabled   = (pre_sel != '0);
  assign run       = enabled && !(pstop && !keep_run);
  assign chain_clr = ctrl_wr || !enabled;

  rti_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W), .MOD_W(MOD_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .expire(expire), .ctrl_wr(ctrl_wr),
    .pre_sel(pre_sel), .mod_sel(mod_sel),
    .irq_en(irq_en), .keep_run(keep_run), .flag(flag)
  );

  rti_prescaler #(.PRE_W(PRE_W), .BASE_EXP(BASE_EXP)) u_pre (
    .clk(clk), .rst(rst), .clr(chain_clr), .run(run),
    .pre_sel(pre_sel), .tick(tick)
  );

  rti_modulus #(.MOD_W(MOD_W)) u_mod (
    .clk(clk), .rst(rst), .clr(chain_clr), .tick(tick),
    .mod_sel(mod_sel), .expire(expire)
  );

  assign irq = flag && irq_en;

  p_disabled_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !enabled |-> !expire);

  p_frozen_no_expire_r6: assert property (@(posedge clk) disable iff (rst)
    (pstop && !keep_run) |-> !expire);
endmodule

// File: tb/rti_timer_tb.sv
module rti_timer_tb;
  localparam int unsigned BASE = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [0:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pstop = 1'b0;
  logic       irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rti_timer #(.BASE_EXP(BASE)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pstop(pstop), .irq(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // called at a negedge; write captured on the following posedge
  task automatic wr(input int a, input int d);
    bus_wr = 1'b1; bus_addr = 1'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_rd = 1'b1; bus_addr = 1'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  function automatic int period(input int p, input int m);
    return (m + 1) << (p + BASE);
  endfunction

  initial begin
    int v;
    int t;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    chk("R2 irq", int'(irq), 0);
    rd(0, v); chk("R2 ctrl", v, 0);
    rd(1, v); chk("R2 cfg", v, 0);

    // R10 config readback, unused bits zero
    wr(1, 8'h7E); rd(1, v); chk("R10 cfg readback", v, 8'h02);
    // R1 control readback, bit 7 zero
    wr(0, 8'hFF); rd(0, v); chk("R1 ctrl readback", v, 8'h7F);
    wr(0, 8'h35); rd(0, v); chk("R1 ctrl fields", v, 8'h35);

    // R3 exhaustive period sweep
    for (int p = 1; p < 8; p++) begin
      for (int m = 0; m < 16; m++) begin
        t = period(p, m);
        wr(1, 8'h81);
        wr(0, (p << 4) | m);
        repeat (t - 1) @(negedge clk);
        chk($sformatf("R3 early p%0d m%0d", p, m), int'(irq), 0);
        @(negedge clk);
        chk($sformatf("R3 expiry p%0d m%0d", p, m), int'(irq), 1);
      end
    end

    // R3 repetition and R8 clear
    t = period(1, 2);
    wr(1, 8'h81);
    wr(0, 8'h12);
    repeat (t) @(negedge clk);
    chk("R3 first period", int'(irq), 1);
    wr(1, 8'h81);
    chk("R8 w1c clears", int'(irq), 0);
    repeat (t - 2) @(negedge clk);
    chk("R3 second early", int'(irq), 0);
    @(negedge clk);
    chk("R3 second period", int'(irq), 1);
    wr(1, 8'h01);
    chk("R8 write 0 keeps flag", int'(irq), 1);

    // R8 set wins over same-edge clear
    wr(1, 8'h81);
    wr(0, 8'h10);
    repeat (3) @(negedge clk);
    wr(1, 8'h81);
    chk("R8 set wins", int'(irq), 1);

    // R4 same-value rewrite restarts
    t = period(2, 1);
    wr(1, 8'h81);
    wr(0, 8'h21);
    repeat (10) @(negedge clk);
    wr(0, 8'h21);
    repeat (t - 1) @(negedge clk);
    chk("R4 no expiry before restarted period", int'(irq), 0);
    @(negedge clk);
    chk("R4 expiry after restart", int'(irq), 1);

    // R6 freeze holds count, resumes
    wr(1, 8'h81);
    wr(0, 8'h10);
    repeat (2) @(negedge clk);
    pstop = 1'b1;
    repeat (10) @(negedge clk);
    chk("R6 frozen no expiry", int'(irq), 0);
    pstop = 1'b0;
    @(negedge clk);
    chk("R6 resume early", int'(irq), 0);
    @(negedge clk);
    chk("R6 resume from held count", int'(irq), 1);

    // R7 keep running in pseudo-stop
    wr(1, 8'h83);
    wr(0, 8'h10);
    pstop = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 early", int'(irq), 0);
    @(negedge clk);
    chk("R7 runs during pstop", int'(irq), 1);
    pstop = 1'b0;

    // R5 disabled
    wr(0, 8'h0F);
    wr(1, 8'h81);
    repeat (3000) @(negedge clk);
    chk("R5 disabled irq", int'(irq), 0);
    rd(1, v); chk("R5 disabled flag", v, 8'h01);

    // R9 enable gating
    wr(1, 8'h80);
    wr(0, 8'h10);
    repeat (5) @(negedge clk);
    chk("R9 masked irq", int'(irq), 0);
    rd(1, v); chk("R9 flag seen", v, 8'h80);
    wr(1, 8'h01);
    chk("R9 unmasked irq", int'(irq), 1);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule